// File: doc/BRIEF.md
# Serially Configured Lookup-Table Routing Fabric

This block is a tiny programmable logic array: two rows, each holding two three-input lookup tables with two outputs apiece, flanked by switch matrices that carry four routing channels. A configuration image is shifted in one bit per enabled clock. Once a completion strobe arrives, the eight-bit input bus is mapped to the four-bit output bus by pure combinational logic. No path from `fab_in` to `fab_out` passes through a register.

Routing is deliberately narrow, so that a placer can stay simple. Each switch matrix carries signals from its top and left sides to its bottom and right sides, and always on the same channel number. A lookup table reads any of the eight channels on its two flanking columns. It can drive only the bus below it. A final crossbar under the last row is the only place where a signal can move to a different channel number.

A small state machine controls the output gate. Its states are S_EMPTY (after reset), S_LOAD (image being shifted) and S_LIVE (fabric driving outputs). Its transitions are:
- S_EMPTY→S_LOAD on `cfg_en` without `cfg_done`.
- Any state→S_LIVE on `cfg_done`.
- S_LIVE→S_LOAD on `cfg_en` without `cfg_done`.
- S_LOAD holds otherwise.

Top module: `lutfab_top`

## Requirements
- R1: A synchronous active-high `rst` clears the whole configuration image to zero and enters S_EMPTY. From the next edge onward, `fab_out` is zero whatever `fab_in` is.
- R2: On each rising edge with `cfg_en` high, the 204-bit image shifts left by one and `cfg_din` enters bit 0. The image is therefore sent most significant bit first, and the image is held when `cfg_en` is low. Image layout:
  - Bits [7:0] hold the crossbar selects.
  - Row r occupies 98 bits starting at 8+98*r.
  - Inside a row, LUT k starts at offset 25*k, and switch matrix column c starts at offset 50+16*c.
- R3: `fab_out` is zero in S_EMPTY and in S_LOAD. This includes any reload that begins after the fabric has gone live.
- R4: A `cfg_done` high at an edge puts the block in S_LIVE. From then on, `fab_out` is the fabric's mapping of `fab_in`.
- R5: If `cfg_en` and `cfg_done` are both high at the same edge, that edge's bit is still shifted in, and the fabric goes live with the updated image.
- R6: Each LUT holds 16 table bits at offsets [24:9] and forms a 3-bit address {a2,a1,a0}. Output 0 is table bit 2*addr and output 1 is table bit 2*addr+1.
- R7: The LUT address bit ai comes from a 3-bit select at offset 3*i. Values 0 to 3 pick channels 0 to 3 of the bus below the switch matrix on the LUT's left (column k). Values 4 to 7 pick channels 0 to 3 below the matrix on its right (column k+1).
- R8: Each switch matrix has four 4-bit enable fields, one bit per channel: top→bottom at [3:0], top→right at [7:4], left→bottom at [11:8] and left→right at [15:12]. Each output channel is the OR of the enabled sources on that same channel number only.
- R9: The fabric is wired as follows:
  - Row 0 tops of columns 0, 1 and 2 take `fab_in[3:0]`, `fab_in[7:4]` and `fab_in[3:0]`.
  - Every row's column-0 left side takes `fab_in[7:4]`, and each column's left side takes the previous column's right side.
  - The LUT outputs of row r form bus L_r, with channels {L1.o1, L1.o0, L0.o1, L0.o0} listed from channel 3 down.
  - Row r+1 takes L_r on its column-0 top, and takes row r's column-c bottom on its column-c top for c>0.
- R10: The 2-bit select at bits [2j+1:2j] picks which channel of the last row's LUT bus drives `fab_out[j]`.
- R11: While live, a change on `fab_in` appears on `fab_out` without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration chain and state machine |
| rst | input | 1 | Synchronous reset, active high |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_din | input | 1 | Serial configuration bit |
| cfg_done | input | 1 | Load-complete strobe; makes the fabric live |
| fab_in | input | 8 | Fabric primary inputs |
| fab_out | output | 4 | Fabric primary outputs, zero unless live |

## Verification
The shift of a configuration bit and the activation strobe can land on the same edge. The bench provokes this by raising `cfg_done` together with the final bit of a second image. The fabric must then compute that second image's mapping. If the last bit were dropped, the whole image would sit one position off and give different outputs. The bench also begins a reload from the live state and checks that the outputs drop to zero on the first shift edge.

// File: rtl/lutfab_pkg.sv
package lutfab_pkg;

    localparam int NCH       = 4;
    localparam int NROW      = 2;
    localparam int NLUT      = 2;
    localparam int NCOL      = NLUT + 1;
    localparam int LUT_IN    = 3;
    localparam int LUT_OUT   = 2;
    localparam int LUT_WORDS = 1 << LUT_IN;
    localparam int LUT_BITS  = LUT_WORDS * LUT_OUT;
    localparam int SEL_W     = $clog2(2 * NCH);
    localparam int XSEL_W    = $clog2(NCH);
    localparam int NIN       = 2 * NCH;
    localparam int NOUT      = NCH;

    typedef struct packed {
        logic [LUT_BITS-1:0]           table_bits;
        logic [LUT_IN-1:0][SEL_W-1:0]  pick;
    } lut_cfg_t;

    typedef struct packed {
        logic [NCH-1:0] l2r;
        logic [NCH-1:0] l2b;
        logic [NCH-1:0] t2r;
        logic [NCH-1:0] t2b;
    } sw_cfg_t;

    typedef struct packed {
        sw_cfg_t  [NCOL-1:0] sw;
        lut_cfg_t [NLUT-1:0] lut;
    } row_cfg_t;

    typedef struct packed {
        row_cfg_t [NROW-1:0]             row;
        logic     [NOUT-1:0][XSEL_W-1:0] xsel;
    } fab_cfg_t;

    localparam int CFG_W = $bits(fab_cfg_t);

    typedef enum logic [1:0] {
        S_EMPTY = 2'd0,
        S_LOAD  = 2'd1,
        S_LIVE  = 2'd2
    } fab_state_t;

endpackage

// File: rtl/lutfab_cfg_ctl.sv
module lutfab_cfg_ctl
    import lutfab_pkg::*;
#(
    parameter int W = CFG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cfg_en,
    input  logic         cfg_din,
    input  logic         cfg_done,
    output logic [W-1:0] cfg_bits,
    output logic         live
);

    fab_state_t st, st_nx;

    // configuration chain, most significant bit arrives first
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_bits <= '0;
        end else if (cfg_en) begin
            cfg_bits <= {cfg_bits[W-2:0], cfg_din};
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= S_EMPTY;
        end else begin
            st <= st_nx;
        end
    end

    // transitions
    always_comb begin
        st_nx = st;
        unique case (st)
            S_EMPTY: begin
                if (cfg_done)    st_nx = S_LIVE;
                else if (cfg_en) st_nx = S_LOAD;
            end
            S_LOAD: begin
                if (cfg_done)    st_nx = S_LIVE;
            end
            S_LIVE: begin
                if (cfg_done)    st_nx = S_LIVE;
                else if (cfg_en) st_nx = S_LOAD;
            end
            default: st_nx = S_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        live = 1'b0;
        unique case (st)
            S_LIVE:  live = 1'b1;
            default: live = 1'b0;
        endcase
    end

    // R2: a shifted bit lands at position 0
    a_r2_shift_in: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> cfg_bits[0] == $past(cfg_din));

    // R2: image is frozen without the enable
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> $stable(cfg_bits));

    // R4 and R5: the strobe always makes the fabric live
    a_r4_done_goes_live: assert property (@(posedge clk) disable iff (rst)
        cfg_done |=> live);

endmodule

// File: rtl/lutfab_switch.sv
module lutfab_switch
    import lutfab_pkg::*;
(
    input  logic [NCH-1:0] top,
    input  logic [NCH-1:0] left,
    input  sw_cfg_t        cfg,
    output logic [NCH-1:0] bottom,
    output logic [NCH-1:0] right
);

    // every channel is joined only to the same channel number
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        assign bottom[ch] = (top[ch] & cfg.t2b[ch]) | (left[ch] & cfg.l2b[ch]);
        assign right[ch]  = (top[ch] & cfg.t2r[ch]) | (left[ch] & cfg.l2r[ch]);
    end

endmodule

// File: rtl/lutfab_lut3.sv
module lutfab_lut3
    import lutfab_pkg::*;
(
    input  logic [NCH-1:0]     bus_l,
    input  logic [NCH-1:0]     bus_r,
    input  lut_cfg_t           cfg,
    output logic [LUT_OUT-1:0] o
);

    localparam int AW = $clog2(LUT_BITS);

    logic [2*NCH-1:0] pool;
    logic [LUT_IN-1:0] addr;
    logic [AW-1:0]     base;

    assign pool = {bus_r, bus_l};

    for (genvar i = 0; i < LUT_IN; i++) begin : g_pick
        assign addr[i] = pool[cfg.pick[i]];
    end

    assign base = {addr, 1'b0};

    for (genvar b = 0; b < LUT_OUT; b++) begin : g_out
        assign o[b] = cfg.table_bits[base + AW'(b)];
    end

endmodule

// File: rtl/lutfab_xbar.sv
module lutfab_xbar
    import lutfab_pkg::*;
(
    input  logic [NCH-1:0]                 chan,
    input  logic [NOUT-1:0][XSEL_W-1:0]    sel,
    output logic [NOUT-1:0]                out
);

    for (genvar j = 0; j < NOUT; j++) begin : g_out
        assign out[j] = chan[sel[j]];
    end

endmodule

// File: rtl/lutfab_top.sv
module lutfab_top
    import lutfab_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_en,
    input  logic            cfg_din,
    input  logic            cfg_done,
    input  logic [NIN-1:0]  fab_in,
    output logic [NOUT-1:0] fab_out
);

    logic [CFG_W-1:0] cfg_bits;
    logic             live;
    fab_cfg_t         cfg;
    logic [NOUT-1:0]  xbar_out;

    lutfab_cfg_ctl #(.W(CFG_W)) u_ctl (
        .clk      (clk),
        .rst      (rst),
        .cfg_en   (cfg_en),
        .cfg_din  (cfg_din),
        .cfg_done (cfg_done),
        .cfg_bits (cfg_bits),
        .live     (live)
    );

    assign cfg = fab_cfg_t'(cfg_bits);

    for (genvar r = 0; r < NROW; r++) begin : g_row
        logic [NCH-1:0] lbus;
        logic [NCH-1:0] unused_edge;

        for (genvar c = 0; c < NCOL; c++) begin : g_col
            logic [NCH-1:0] top, left, bot, right;

            if (r == 0) begin : g_top_in
                if (c % 2 == 0) begin : g_lo
                    assign top = fab_in[NCH-1:0];
                end else begin : g_hi
                    assign top = fab_in[NIN-1:NCH];
                end
            end else if (c == 0) begin : g_top_lut
                assign top = g_row[r-1].lbus;
            end else begin : g_top_sw
                assign top = g_row[r-1].g_col[c].bot;
            end

            if (c == 0) begin : g_left_in
                assign left = fab_in[NIN-1:NCH];
            end else begin : g_left_chain
                assign left = g_row[r].g_col[c-1].right;
            end

            lutfab_switch u_sw (
                .top    (top),
                .left   (left),
                .cfg    (cfg.row[r].sw[c]),
                .bottom (bot),
                .right  (right)
            );

            if (c == NCOL - 1) begin : g_edge
                assign unused_edge = right;
            end
        end

        for (genvar k = 0; k < NLUT; k++) begin : g_lut
            lutfab_lut3 u_lut (
                .bus_l (g_row[r].g_col[k].bot),
                .bus_r (g_row[r].g_col[k+1].bot),
                .cfg   (cfg.row[r].lut[k]),
                .o     (lbus[LUT_OUT*k +: LUT_OUT])
            );
        end
    end

    lutfab_xbar u_xbar (
        .chan (g_row[NROW-1].lbus),
        .sel  (cfg.xsel),
        .out  (xbar_out)
    );

    assign fab_out = live ? xbar_out : '0;

    // R1: reset leaves the outputs dark
    a_r1_reset_dark: assert property (@(posedge clk)
        rst |=> fab_out == '0);

    // R3: a shift edge without the strobe leaves the outputs dark
    a_r3_dark_while_loading: assert property (@(posedge clk) disable iff (rst)
        (cfg_en && !cfg_done) |=> fab_out == '0);

endmodule

// File: tb/lutfab_top_tb_top.sv
module lutfab_top_tb_top;

    localparam int CW      = 204;
    localparam int ROW_W   = 98;
    localparam int NVEC    = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_en = 1'b0;
    logic       cfg_din = 1'b0;
    logic       cfg_done = 1'b0;
    logic [7:0] fab_in = 8'h00;
    logic [3:0] fab_out;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [CW-1:0] cv;

    always #4 clk = ~clk;

    lutfab_top dut_i (
        .clk      (clk),
        .rst      (rst),
        .cfg_en   (cfg_en),
        .cfg_din  (cfg_din),
        .cfg_done (cfg_done),
        .fab_in   (fab_in),
        .fab_out  (fab_out)
    );

    // {fab_in, expected fab_out} for image A
    localparam logic [11:0] VEC_A [NVEC] = '{
        {8'h00, 4'h8}, {8'h01, 4'hA}, {8'h03, 4'hC}, {8'h10, 4'h3},
        {8'h13, 4'h7}, {8'h20, 4'h1}, {8'h11, 4'h5}, {8'hE2, 4'h3},
        {8'hFF, 4'h7}, {8'h0C, 4'h8}
    };

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp_v);
        total++;
        if (act !== exp_v) begin
            bad++;
            $display("FAIL %s: fab_out=%h expected=%h", tag, act, exp_v);
        end
    endtask

    task automatic put(input int pos, input int w, input logic [15:0] val);
        for (int b = 0; b < w; b++) cv[pos + b] = val[b];
    endtask

    function automatic int sw_at(input int r, input int c);
        return 8 + ROW_W * r + 50 + 16 * c;
    endfunction

    function automatic int lut_at(input int r, input int k);
        return 8 + ROW_W * r + 25 * k;
    endfunction

    task automatic set_lut(input int r, input int k, input int s0, input int s1,
                           input int s2, input logic [15:0] tbl);
        put(lut_at(r, k) + 0, 3, 16'(s0));
        put(lut_at(r, k) + 3, 3, 16'(s1));
        put(lut_at(r, k) + 6, 3, 16'(s2));
        put(lut_at(r, k) + 9, 16, tbl);
    endtask

    // shift cv MSB first; strobe cfg_done with the final bit when asked
    task automatic load(input bit done_on_last, input bit stop_after_first);
        for (int i = CW - 1; i >= 0; i--) begin
            @(negedge clk);
            cfg_en   = 1'b1;
            cfg_din  = cv[i];
            cfg_done = done_on_last && (i == 0);
            if (stop_after_first && i == CW - 1) begin
                @(negedge clk);
                cfg_en = 1'b0;
                #1 chk("R3 reload dark", fab_out, 4'h0);
            end
        end
        @(negedge clk);
        cfg_en = 1'b0; cfg_din = 1'b0; cfg_done = 1'b0;
    endtask

    initial begin : watchdog
        #(8 * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: run hung");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        // R1 reset state
        fab_in = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1 chk("R1 reset dark", fab_out, 4'h0);

        // image A: parity/majority/AND/OR through both rows
        cv = '0;
        put(sw_at(0, 0) + 0, 4, 16'hF);
        put(sw_at(0, 1) + 0, 4, 16'hF);
        set_lut(0, 0, 0, 1, 4, 16'hE994);
        set_lut(0, 1, 0, 1, 2, 16'hEAA8);
        put(sw_at(1, 0) + 0, 4, 16'hF);
        put(sw_at(1, 0) + 4, 4, 16'h8);
        put(sw_at(1, 1) + 8, 4, 16'h8);
        set_lut(1, 0, 0, 1, 2, 16'hE4E4);
        set_lut(1, 1, 3, 0, 0, 16'h6666);
        put(0, 2, 16'd2); put(2, 2, 16'd0); put(4, 2, 16'd1); put(6, 2, 16'd3);

        fab_in = 8'h00;
        load(1'b0, 1'b0);
        #1 chk("R3 loaded but not done", fab_out, 4'h0);

        @(negedge clk); cfg_done = 1'b1;
        @(negedge clk); cfg_done = 1'b0;
        #1 chk("R4 live after strobe", fab_out, 4'h8);

        // R6 R7 R8 R9 R10 table walk
        for (int i = 0; i < NVEC; i++) begin
            fab_in = VEC_A[i][11:4];
            #2 chk("R6/R8/R9/R10 image A vector", fab_out, VEC_A[i][3:0]);
        end

        // R11 no clock needed
        @(posedge clk); #1;
        fab_in = 8'h10;
        #1 chk("R11 combinational path", fab_out, 4'h3);

        // image B: right-side selects and left-to-right chain
        cv = '0;
        put(sw_at(0, 0) + 12, 4, 16'hF);
        put(sw_at(0, 1) + 8, 4, 16'hF);
        set_lut(0, 0, 5, 6, 7, 16'hE4E4);
        put(sw_at(1, 0) + 0, 4, 16'hF);
        set_lut(1, 0, 0, 1, 0, 16'hE4E4);
        put(0, 2, 16'd0); put(2, 2, 16'd1); put(4, 2, 16'd2); put(6, 2, 16'd3);

        // R3 reload goes dark, R5 last bit and strobe share an edge
        load(1'b1, 1'b1);
        fab_in = 8'h20; #1 chk("R5/R7 in5 via right select", fab_out, 4'h1);
        fab_in = 8'h40; #1 chk("R7/R8 in6 via l2r chain", fab_out, 4'h2);
        fab_in = 8'h60; #1 chk("R8 both channels", fab_out, 4'h3);
        fab_in = 8'h9F; #1 chk("R7 unselected inputs ignored", fab_out, 4'h0);

        // R1 reset while live
        fab_in = 8'h60;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1 chk("R1 reset from live", fab_out, 4'h0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule